// File: doc/BRIEF.md
# Variable Segment Hole Allocator

This block keeps an ordered list of free memory holes, each described by a size and a base address. It places variable-sized segments into those holes. A requester selects one of four placement policies, supplies a size and pulses a start strobe. The block then walks the list one hole per cycle and picks a hole according to the chosen policy. It reports the index and base of that hole, and then carves the segment off the bottom of the hole. A hole that is consumed exactly is deleted, and the holes behind it close up the gap, so the list stays in order.

A preload port builds the list before use. It has a clear strobe and a push strobe that appends one hole at the tail. The next-fit policy uses a roving position that survives from one request to the next. Merging freed space back into the list is left to other logic.

Top module: `seg_hole_alloc`

## Requirements
- R1: `pl_clear` empties the list and returns the roving position to index 0. `pl_push` appends (`pl_size`, `pl_base`) at the tail. A push made while the list already holds `N_HOLES` (default 8) entries is dropped.
- R2: With `req_policy` = 0 (first fit), the grant goes to the lowest-indexed hole whose size is at least `req_size`.
- R3: With `req_policy` = 1 (next fit), the scan begins at the roving position, wraps past the tail to index 0, and takes the first hole that is large enough. Every grant, under any policy, moves the roving position to the granted index. If that hole was deleted and was the last entry, the position becomes 0.
- R4: With `req_policy` = 2 (best fit), the grant goes to the smallest hole that is still large enough. Ties go to the lower index.
- R5: With `req_policy` = 3 (worst fit), the grant goes to the largest hole, provided it is large enough. Ties go to the lower index.
- R6: On a grant, `grant_base` equals the hole's base before the allocation. A hole larger than the request shrinks by `req_size`, and its base advances by `req_size`.
- R7: A hole whose size equals `req_size` is removed on its grant. Every later hole moves up one index, and their relative order is kept.
- R8: A request fails when no hole is large enough, when `req_size` is 0, or when the list is empty. A failed request leaves every hole unchanged.
- R9: `req_start` is accepted only while `busy` is low. `busy` stays high until `done`. `done` is a one-cycle pulse carrying exactly one of `grant` or `fail`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pl_clear | input | 1 | Empty the hole list (ignored while busy) |
| pl_push | input | 1 | Append one hole at the tail (ignored while busy) |
| pl_size | input | SZ_W | Size of the hole being pushed |
| pl_base | input | BASE_W | Base of the hole being pushed |
| req_start | input | 1 | Start a placement request |
| req_size | input | SZ_W | Requested segment size |
| req_policy | input | 2 | 0 first, 1 next, 2 best, 3 worst fit |
| busy | output | 1 | A request is in progress |
| done | output | 1 | One-cycle completion pulse |
| grant | output | 1 | Request placed (valid with done) |
| fail | output | 1 | No suitable hole (valid with done) |
| grant_idx | output | IDX_W | List index of the chosen hole |
| grant_base | output | BASE_W | Base address given to the segment |

## Verification
The bench replays the same seven-hole list and three-request sequence under every policy. Wrong comparison logic therefore shows up as a different index or base for the same stimulus. An off-by-one in the close-up shift, or a missing exact-fit deletion, makes the index of a later grant wrong. Likewise, a roving position that is not cleared, or not wrapped, sends next fit to the wrong hole. The bench also provokes ties, an oversize request, a zero-size request, an empty list and an over-full preload. A design that broke ties toward the higher index, or that edited the list on a failed request, would give a different grant on the request that follows.

// File: rtl/hva_pkg.sv
// Shared types for the segment hole allocator.
// Assumes nothing beyond a 2-bit policy select at the block edge.
package hva_pkg;
    typedef enum logic [1:0] {
        POL_FIRST = 2'd0,
        POL_NEXT  = 2'd1,
        POL_BEST  = 2'd2,
        POL_WORST = 2'd3
    } fit_pol_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SCAN  = 2'd1,
        ST_APPLY = 2'd2
    } alloc_st_e;
endpackage

// File: rtl/hva_fit_judge.sv
// Decides whether the hole now under the scan should replace the candidate
// held so far. The scan visits holes in policy order, so a strict
// comparison keeps the earliest-visited hole on ties.
module hva_fit_judge
    import hva_pkg::*;
#(
    parameter int SZ_W = 8
) (
    input  fit_pol_e          policy,
    input  logic [SZ_W-1:0]   req,
    input  logic [SZ_W-1:0]   cand,
    input  logic              have,
    input  logic [SZ_W-1:0]   kept,
    output logic              take
);
    logic fits;

    // Pick a new candidate according to the placement policy.
    always_comb begin
        fits = (cand >= req);
        unique case (policy)
            POL_BEST:  take = fits && (!have || cand < kept);
            POL_WORST: take = fits && (!have || cand > kept);
            default:   take = fits && !have;
        endcase
    end
endmodule

// File: rtl/hva_hole_list.sv
// Ordered storage of free holes (size, base) with tail append, in-place
// shrink and ordered deletion. Assumes the caller never commits an index
// at or beyond the current count, and commits at most one change per cycle.
module hva_hole_list #(
    parameter int N      = 8,
    parameter int SZ_W   = 8,
    parameter int BASE_W = 10,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1,
    localparam int CNT_W = $clog2(N + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              push,
    input  logic [SZ_W-1:0]   push_size,
    input  logic [BASE_W-1:0] push_base,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [SZ_W-1:0]   rd_size,
    output logic [BASE_W-1:0] rd_base,
    output logic [CNT_W-1:0]  cnt,
    input  logic              cmt,
    input  logic [IDX_W-1:0]  cmt_idx,
    input  logic [SZ_W-1:0]   cmt_amt
);
    logic [SZ_W-1:0]   size_q [N];
    logic [BASE_W-1:0] base_q [N];
    logic [SZ_W-1:0]   sel_size;
    logic              exact;

    // Read ports for the scan and for the hole being committed.
    always_comb begin
        rd_size  = size_q[rd_idx];
        rd_base  = base_q[rd_idx];
        sel_size = size_q[cmt_idx];
        exact    = (sel_size == cmt_amt);
    end

    // Maintain the list: clear, append, shrink, or delete with close-up.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
            for (int i = 0; i < N; i++) begin
                size_q[i] <= '0;
                base_q[i] <= '0;
            end
        end else if (clr) begin
            cnt <= '0;
        end else if (push) begin
            if (cnt < CNT_W'(N)) begin
                size_q[cnt[IDX_W-1:0]] <= push_size;
                base_q[cnt[IDX_W-1:0]] <= push_base;
                cnt <= cnt + 1'b1;
            end
        end else if (cmt) begin
            if (exact) begin
                for (int i = 0; i < N - 1; i++) begin
                    if (i >= int'(cmt_idx)) begin
                        size_q[i] <= size_q[i+1];
                        base_q[i] <= base_q[i+1];
                    end
                end
                cnt <= cnt - 1'b1;
            end else begin
                size_q[cmt_idx] <= sel_size - cmt_amt;
                base_q[cmt_idx] <= base_q[cmt_idx] + BASE_W'(cmt_amt);
            end
        end
    end

    assert_cnt_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CNT_W'(N));

    assert_remove_drops_one_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmt && !clr && !push && exact) |=> (cnt == $past(cnt) - 1'b1));

    assert_shrink_amount_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmt && !clr && !push && !exact) |=>
            (size_q[$past(cmt_idx)] == $past(sel_size) - $past(cmt_amt)));
endmodule

// File: rtl/seg_hole_alloc.sv
// Segment placement engine: scans the hole list one entry per cycle under
// the selected policy, then shrinks or deletes the chosen hole. Assumes the
// preload port is used only while idle (it is ignored otherwise).
module seg_hole_alloc
    import hva_pkg::*;
#(
    parameter int N_HOLES = 8,
    parameter int SZ_W    = 8,
    parameter int BASE_W  = 10,
    localparam int IDX_W  = (N_HOLES > 1) ? $clog2(N_HOLES) : 1,
    localparam int CNT_W  = $clog2(N_HOLES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pl_clear,
    input  logic              pl_push,
    input  logic [SZ_W-1:0]   pl_size,
    input  logic [BASE_W-1:0] pl_base,
    input  logic              req_start,
    input  logic [SZ_W-1:0]   req_size,
    input  logic [1:0]        req_policy,
    output logic              busy,
    output logic              done,
    output logic              grant,
    output logic              fail,
    output logic [IDX_W-1:0]  grant_idx,
    output logic [BASE_W-1:0] grant_base
);
    alloc_st_e         st;
    fit_pol_e          pol_r;
    logic [SZ_W-1:0]   req_r;
    logic [IDX_W-1:0]  pos, ptr, best_idx;
    logic [CNT_W-1:0]  steps, cnt;
    logic              found, take, cmt;
    logic [SZ_W-1:0]   best_size, rd_size;
    logic [BASE_W-1:0] best_base, rd_base;
    logic              idle;

    // Gate the preload port and the commit strobe by the engine state.
    always_comb begin
        idle = (st == ST_IDLE);
        busy = !idle;
        cmt  = (st == ST_APPLY) && found;
    end

    hva_hole_list #(.N(N_HOLES), .SZ_W(SZ_W), .BASE_W(BASE_W)) u_list (
        .clk(clk), .rst_n(rst_n),
        .clr(pl_clear && idle), .push(pl_push && idle),
        .push_size(pl_size), .push_base(pl_base),
        .rd_idx(pos), .rd_size(rd_size), .rd_base(rd_base), .cnt(cnt),
        .cmt(cmt), .cmt_idx(best_idx), .cmt_amt(req_r)
    );

    hva_fit_judge #(.SZ_W(SZ_W)) u_judge (
        .policy(pol_r), .req(req_r), .cand(rd_size),
        .have(found), .kept(best_size), .take(take)
    );

    // Sequence a request: accept, scan each hole once, then commit and report.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= ST_IDLE;
            pol_r <= POL_FIRST;
            req_r <= '0;
            pos <= '0;
            ptr <= '0;
            steps <= '0;
            found <= 1'b0;
            best_idx <= '0;
            best_size <= '0;
            best_base <= '0;
            done <= 1'b0;
            grant <= 1'b0;
            fail <= 1'b0;
            grant_idx <= '0;
            grant_base <= '0;
        end else begin
            done <= 1'b0;
            grant <= 1'b0;
            fail <= 1'b0;
            unique case (st)
                ST_IDLE: begin
                    if (pl_clear) ptr <= '0;
                    if (req_start) begin
                        pol_r <= fit_pol_e'(req_policy);
                        req_r <= req_size;
                        found <= 1'b0;
                        steps <= '0;
                        pos <= (fit_pol_e'(req_policy) == POL_NEXT) ? ptr : '0;
                        st <= (req_size == '0 || cnt == '0) ? ST_APPLY : ST_SCAN;
                    end
                end
                ST_SCAN: begin
                    if (take) begin
                        found <= 1'b1;
                        best_idx <= pos;
                        best_size <= rd_size;
                        best_base <= rd_base;
                    end
                    pos <= (CNT_W'(pos) == cnt - 1'b1) ? '0 : pos + 1'b1;
                    steps <= steps + 1'b1;
                    if (steps == cnt - 1'b1) st <= ST_APPLY;
                end
                default: begin
                    done <= 1'b1;
                    grant <= found;
                    fail <= !found;
                    if (found) begin
                        grant_idx <= best_idx;
                        grant_base <= best_base;
                        if (best_size == req_r && CNT_W'(best_idx) == cnt - 1'b1)
                            ptr <= '0;
                        else
                            ptr <= best_idx;
                    end
                    st <= ST_IDLE;
                end
            endcase
        end
    end

    assert_done_one_outcome_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (grant ^ fail));

    assert_ptr_in_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (CNT_W'(ptr) < cnt) || (ptr == '0));

    assert_fail_keeps_list_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_APPLY && !found) |=> $stable(cnt));

    assert_idx_below_count_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (done && grant) |-> (CNT_W'(grant_idx) < $past(cnt)));
endmodule

// File: tb/sim_seg_hole_alloc.sv
module sim_seg_hole_alloc;
    localparam int N = 8, SZ_W = 8, BASE_W = 10, IDX_W = 3;

    logic clk = 1'b0, rst_n = 1'b0;
    logic pl_clear = 0, pl_push = 0, req_start = 0;
    logic [SZ_W-1:0] pl_size = 0, req_size = 0;
    logic [BASE_W-1:0] pl_base = 0;
    logic [1:0] req_policy = 0;
    logic busy, done, grant, fail;
    logic [IDX_W-1:0] grant_idx;
    logic [BASE_W-1:0] grant_base;
    int n_chk = 0, n_bad = 0;

    always #2 clk = ~clk;

    seg_hole_alloc #(.N_HOLES(N), .SZ_W(SZ_W), .BASE_W(BASE_W)) u0 (
        .clk(clk), .rst_n(rst_n), .pl_clear(pl_clear), .pl_push(pl_push),
        .pl_size(pl_size), .pl_base(pl_base), .req_start(req_start),
        .req_size(req_size), .req_policy(req_policy), .busy(busy), .done(done),
        .grant(grant), .fail(fail), .grant_idx(grant_idx), .grant_base(grant_base)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic push_hole(input int sz, input int bs);
        @(negedge clk);
        pl_push = 1; pl_size = SZ_W'(sz); pl_base = BASE_W'(bs);
        @(negedge clk);
        pl_push = 0;
    endtask

    // Standard list: sizes 10,4,20,18,7,9,12 with base = index*64.
    task automatic load_std();
        int sz[7] = '{10, 4, 20, 18, 7, 9, 12};
        @(negedge clk); pl_clear = 1; @(negedge clk); pl_clear = 0;
        for (int i = 0; i < 7; i++) push_hole(sz[i], i * 64);
    endtask

    // Issue one request and compare the outcome; exp_idx < 0 means fail expected.
    task automatic alloc(input string req, input int pol, input int sz,
                         input int exp_idx, input int exp_base);
        int waited = 0;
        @(negedge clk);
        req_start = 1; req_policy = 2'(pol); req_size = SZ_W'(sz);
        @(negedge clk);
        req_start = 0;
        check({req, " busy"}, int'(busy || done), 1);
        while (!done && waited < 40) begin
            @(negedge clk);
            waited++;
        end
        check({req, " done"}, int'(done), 1);
        if (exp_idx < 0) begin
            check({req, " fail"}, int'(fail), 1);
            check({req, " grant"}, int'(grant), 0);
        end else begin
            check({req, " grant"}, int'(grant), 1);
            check({req, " idx"}, int'(grant_idx), exp_idx);
            check({req, " base"}, int'(grant_base), exp_base);
        end
        @(negedge clk);
        check({req, " done pulse"}, int'(done), 0);
    endtask

    task automatic t_reset();
        check("R9 reset busy", int'(busy), 0);
        check("R9 reset done", int'(done), 0);
        check("R9 reset grant", int'(grant), 0);
        check("R9 reset fail", int'(fail), 0);
    endtask

    task automatic t_first();
        load_std();
        alloc("R2 ff 12", 0, 12, 2, 128);
        alloc("R7 ff 10 exact", 0, 10, 0, 0);
        alloc("R2 ff 9 after shift", 0, 9, 2, 192);
    endtask

    task automatic t_best();
        load_std();
        alloc("R4 bf 12", 2, 12, 6, 384);
        alloc("R4 bf 10", 2, 10, 0, 0);
        alloc("R7 bf 9 after removals", 2, 9, 4, 320);
    endtask

    task automatic t_worst();
        load_std();
        alloc("R5 wf 12", 3, 12, 2, 128);
        alloc("R5 wf 10", 3, 10, 3, 192);
        alloc("R5 wf 9", 3, 9, 6, 384);
    endtask

    task automatic t_next();
        load_std();
        alloc("R1 R3 nf 12 after clear", 1, 12, 2, 128);
        alloc("R3 nf 10", 1, 10, 3, 192);
        alloc("R3 nf 9", 1, 9, 5, 320);
        alloc("R3 nf 11 from pointer", 1, 11, 5, 384);
        alloc("R6 R3 nf 10 wrap", 1, 10, 0, 0);
    endtask

    // List here: 4@64, 8@140, 8@202, 7@256, 1@395.
    task automatic t_fail_and_ties();
        alloc("R8 too big", 0, 50, -1, 0);
        alloc("R8 list kept", 0, 4, 0, 64);
        alloc("R5 tie low idx", 3, 8, 0, 140);
        alloc("R4 best 7", 2, 7, 1, 256);
        alloc("R8 zero size", 0, 0, -1, 0);
        alloc("R6 shrunk base", 0, 1, 0, 202);
        alloc("R6 base advanced", 0, 7, 0, 203);
    endtask

    task automatic t_best_tie_and_empty();
        @(negedge clk); pl_clear = 1; @(negedge clk); pl_clear = 0;
        alloc("R8 empty list", 0, 1, -1, 0);
        push_hole(6, 0); push_hole(3, 10); push_hole(6, 20);
        alloc("R4 tie low idx", 2, 5, 0, 0);
    endtask

    task automatic t_overfill();
        @(negedge clk); pl_clear = 1; @(negedge clk); pl_clear = 0;
        for (int i = 0; i < N; i++) push_hole(5, i * 8);
        push_hole(100, 900);
        alloc("R1 push when full dropped", 3, 100, -1, 0);
        alloc("R1 last kept entry", 3, 5, 0, 0);
    endtask

    initial begin
        fork
            begin
                repeat (3) @(negedge clk);
                rst_n = 1;
                t_reset();
                t_first();
                t_best();
                t_worst();
                t_next();
                t_fail_and_ties();
                t_best_tie_and_empty();
                t_overfill();
            end
            begin
                repeat (20000) @(negedge clk);
                n_chk++; n_bad++;
                $display("FAIL R9 watchdog: actual 0 expected 1");
            end
        join_any
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule